// File: doc/BRIEF.md
# Two-Level Mealy Controller with Microinstruction-Relative State Codes

This block is a Mealy control unit split into two levels. A combinational first level looks at the current state and the condition inputs. From them it produces only two small codes: a microinstruction code, and a short partial code for the next state. The partial code only has to tell apart the states that can follow one particular microinstruction, so it is narrower than a full state code.

Two lookup tables on the second level both take the microinstruction code. The state converter table is addressed by the partial code and the microinstruction code together. It returns the full next-state code, which the state register loads. The microoperation table turns the microinstruction code into the output vector.

Both tables are registered on the falling clock edge. The state register loads on the rising edge. A result therefore reaches the state register half a cycle after it is formed, with no extra cycle of latency. The microoperation vector is held from one falling edge to the next.

A fixed example control table is built in. It has 6 states, 3 condition inputs, 4 microinstructions and 6 microoperation outputs. States use codes 0 to 5, and S0 (code 0) is the initial state.

Top module: `mfsm_top`

## Requirements
- R1: A falling edge seen with `rst_n` low drives `mop_out` to all zeros. Once `rst_n` returns high, the first transition is taken from S0. This holds both at start-up and when reset is applied in the middle of a run.
- R2: At each falling edge with `rst_n` high, `mop_out` takes the microoperation word of the transition selected by the current state and `x_in`. That word then holds until the next falling edge.
- R3: On each rising edge, the state moves to the target of the transition selected at the previous falling edge. The transitions are: S0: x0→S1/M0, else S2/M1; S1: x1→S3/M0, else S4/M1; S2: x2→S5/M2, else S2/M1; S3: x0&x1→S0/M3, else S5/M2; S4: x2→S0/M3, else S1/M0; S5: x1→S0/M2, else S4/M1. Here xk is bit k of `x_in`.
- R4: Within a state, the conditional transition wins whenever its condition holds. The other transition is taken otherwise, whatever the ignored inputs are. In particular, S3 with only one of x0 and x1 high takes S5/M2.
- R5: The microoperation words, written MSB first, are M0 = 000011, M1 = 001100, M2 = 110000 and M3 = 100101. Microinstruction k uses code k.
- R6: States that follow the same microinstruction are told apart by a 1-bit partial code. M0 leads to S1 or S3, M1 to S2 or S4, M2 to S5 or S0, and M3 only to S0. Each pair must reach its own distinct target.
- R7: `mop_out` does not change at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. The tables read on the falling edge and the state register loads on the rising edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| x_in | input | 3 | Condition inputs x2..x0. |
| mop_out | output | 6 | Microoperation vector, registered on the falling edge. |

## Verification
On every falling edge, two things happen at once from the same microinstruction code: the microoperation table decodes the output, and the converter table resolves the next state. A wrong converter entry shows up only in the following cycle's output. The bench therefore drives pairs of transitions that share a microinstruction but lead to different targets, for example S1→S3 and S4→S1 under M0. It compares each output against a behavioural reference model, and the error becomes visible one step later. Reset is also applied while inputs keep selecting live transitions. In that case the falling edge must give zeros, and the run must restart from S0 rather than from the transition that was pending.

// File: rtl/mfsm_pkg.sv
// Package: shared sizes, row type and the built-in example control table.
// Assumes every state has one default row (empty mask) after its
// conditional row, and that partial codes are unique within each
// microinstruction group.
package mfsm_pkg;

    localparam int NUM_STATES = 6;
    localparam int NUM_IN     = 3;
    localparam int NUM_OUT    = 6;
    localparam int NUM_MI     = 4;
    localparam int MAX_GROUP  = 2;
    localparam int NUM_ROWS   = 12;

    localparam int ST_W       = $clog2(NUM_STATES);
    localparam int MI_W       = $clog2(NUM_MI);
    localparam int PART_W     = $clog2(MAX_GROUP);
    localparam int CONV_AW    = PART_W + MI_W;
    localparam int CONV_DEPTH = 1 << CONV_AW;

    localparam logic [ST_W-1:0] INIT_STATE = '0;

    // Codes the first level emits for an illegal state: they point at a
    // converter slot that no row uses, which returns the initial state.
    localparam logic [MI_W-1:0]   RECOVER_MI   = '1;
    localparam logic [PART_W-1:0] RECOVER_PART = '1;

    typedef struct packed {
        logic [ST_W-1:0]   cur;
        logic [NUM_IN-1:0] mask;
        logic [NUM_IN-1:0] val;
        logic [ST_W-1:0]   nxt;
        logic [MI_W-1:0]   mi;
        logic [PART_W-1:0] part;
    } row_t;

    // Transition rows; within one state the lower index has priority.
    localparam row_t ROWS [NUM_ROWS] = '{
        '{3'd0, 3'b001, 3'b001, 3'd1, 2'd0, 1'b0},
        '{3'd0, 3'b000, 3'b000, 3'd2, 2'd1, 1'b0},
        '{3'd1, 3'b010, 3'b010, 3'd3, 2'd0, 1'b1},
        '{3'd1, 3'b000, 3'b000, 3'd4, 2'd1, 1'b1},
        '{3'd2, 3'b100, 3'b100, 3'd5, 2'd2, 1'b0},
        '{3'd2, 3'b000, 3'b000, 3'd2, 2'd1, 1'b0},
        '{3'd3, 3'b011, 3'b011, 3'd0, 2'd3, 1'b0},
        '{3'd3, 3'b000, 3'b000, 3'd5, 2'd2, 1'b0},
        '{3'd4, 3'b100, 3'b100, 3'd0, 2'd3, 1'b0},
        '{3'd4, 3'b000, 3'b000, 3'd1, 2'd0, 1'b0},
        '{3'd5, 3'b010, 3'b010, 3'd0, 2'd2, 1'b1},
        '{3'd5, 3'b000, 3'b000, 3'd4, 2'd1, 1'b1}
    };

    // Microoperation word for each microinstruction code.
    localparam logic [NUM_OUT-1:0] MOP_WORDS [NUM_MI] = '{
        6'b000011, 6'b001100, 6'b110000, 6'b100101
    };

    // Converter table entry: the target of any row whose {part, mi} matches
    // the address, else the initial state.
    function automatic logic [ST_W-1:0] conv_entry(input logic [CONV_AW-1:0] addr);
        logic [ST_W-1:0] word;
        word = INIT_STATE;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if ({ROWS[i].part, ROWS[i].mi} == addr) begin
                word = ROWS[i].nxt;
            end
        end
        return word;
    endfunction

endpackage

// File: rtl/mfsm_first_level.sv
// First level: combinational match of the current state and the inputs
// against the transition rows. It yields only the microinstruction code and
// the partial next-state code. Assumes the lowest matching row index wins.
// A state with no row yields the recovery codes.
module mfsm_first_level
    import mfsm_pkg::*;
(
    input  logic [ST_W-1:0]   state_i,
    input  logic [NUM_IN-1:0] x_i,
    output logic [MI_W-1:0]   mi_code_o,
    output logic [PART_W-1:0] part_code_o
);

    // Priority row match: later rows are overwritten by earlier ones.
    always_comb begin
        mi_code_o   = RECOVER_MI;
        part_code_o = RECOVER_PART;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (ROWS[i].cur == state_i && ((x_i & ROWS[i].mask) == ROWS[i].val)) begin
                mi_code_o   = ROWS[i].mi;
                part_code_o = ROWS[i].part;
            end
        end
    end

endmodule

// File: rtl/mfsm_conv_rom.sv
// State code converter: a table addressed by {partial code, microinstruction
// code}. It is registered on the falling clock edge so the full next-state
// code is settled before the following rising edge. Assumes a synchronous
// active-low reset that loads the initial state code.
module mfsm_conv_rom
    import mfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PART_W-1:0] part_i,
    input  logic [MI_W-1:0]   mi_i,
    output logic [ST_W-1:0]   next_state_o
);

    logic [ST_W-1:0] table_w [CONV_DEPTH];

    // One constant table word per address, computed from the row list.
    for (genvar a = 0; a < CONV_DEPTH; a++) begin : g_word
        assign table_w[a] = conv_entry(CONV_AW'(a));
    end

    // Falling-edge registered read.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            next_state_o <= INIT_STATE;
        end else begin
            next_state_o <= table_w[{part_i, mi_i}];
        end
    end

endmodule

// File: rtl/mfsm_mop_rom.sv
// Microoperation decoder: a table addressed by the microinstruction code,
// registered on the falling clock edge. It also serves as the output
// register. Assumes a synchronous active-low reset that clears the outputs.
module mfsm_mop_rom
    import mfsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MI_W-1:0]    mi_i,
    output logic [NUM_OUT-1:0] mop_o
);

    logic [NUM_OUT-1:0] table_w [NUM_MI];

    // Table words taken from the package.
    for (genvar k = 0; k < NUM_MI; k++) begin : g_word
        assign table_w[k] = MOP_WORDS[k];
    end

    // Falling-edge registered read.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            mop_o <= '0;
        end else begin
            mop_o <= table_w[mi_i];
        end
    end

endmodule

// File: rtl/mfsm_top.sv
// Two-level Mealy controller. The state register (rising edge) feeds the
// first level, whose codes address the converter and microoperation tables
// (falling edge). The converter output loads the state register on the
// next rising edge. Assumes a free-running clock and a synchronous
// active-low reset held for at least one full cycle.
module mfsm_top
    import mfsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  x_in,
    output logic [NUM_OUT-1:0] mop_out
);

    logic [ST_W-1:0]   state_q;
    logic [ST_W-1:0]   conv_q;
    logic [MI_W-1:0]   mi_code;
    logic [PART_W-1:0] part_code;

    mfsm_first_level u_first (
        .state_i     (state_q),
        .x_i         (x_in),
        .mi_code_o   (mi_code),
        .part_code_o (part_code)
    );

    mfsm_conv_rom u_conv (
        .clk          (clk),
        .rst_n        (rst_n),
        .part_i       (part_code),
        .mi_i         (mi_code),
        .next_state_o (conv_q)
    );

    mfsm_mop_rom u_mop (
        .clk   (clk),
        .rst_n (rst_n),
        .mi_i  (mi_code),
        .mop_o (mop_out)
    );

    // State register: loads the converted next-state code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_STATE;
        end else begin
            state_q <= conv_q;
        end
    end

endmodule

// File: rtl/mfsm_checker.sv
// Checker for mfsm_top: relates the registered outputs to the state
// register. Attached through bind. Assumes the reset is synchronous and
// active low.
module mfsm_checker
    import mfsm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] mop_out,
    input logic [ST_W-1:0]    state_q
);

    // True when w is one of the table words.
    function automatic logic is_word(input logic [NUM_OUT-1:0] w);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_MI; k++) begin
            if (MOP_WORDS[k] == w) hit = 1'b1;
        end
        return hit;
    endfunction

    // True when some transition issues word w and leads to state s.
    function automatic logic in_group(input logic [NUM_OUT-1:0] w, input logic [ST_W-1:0] s);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (ROWS[i].nxt == s && MOP_WORDS[ROWS[i].mi] == w) hit = 1'b1;
        end
        return hit;
    endfunction

    AST_RESET_EXIT_INIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> state_q == INIT_STATE); // R1
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> state_q < ST_W'(NUM_STATES)); // R3
    AST_WORD_KNOWN: assert property (@(negedge clk) disable iff (!rst_n) $past(rst_n) |-> is_word(mop_out)); // R5
    AST_TARGET_IN_GROUP: assert property (@(negedge clk) disable iff (!rst_n) $past(rst_n) |-> in_group(mop_out, state_q)); // R6

endmodule

bind mfsm_top mfsm_checker chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mop_out (mop_out),
    .state_q (state_q)
);

// File: tb/mfsm_top_test.sv
`timescale 1ns/1ps
module mfsm_top_test;

    localparam logic [5:0] W0 = 6'b000011;
    localparam logic [5:0] W1 = 6'b001100;
    localparam logic [5:0] W2 = 6'b110000;
    localparam logic [5:0] W3 = 6'b100101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] x_in = 3'b000;
    logic [5:0] mop_out;

    int vectors = 0;
    int miscompares = 0;
    int mstate = 0;
    logic [5:0] last_y;

    mfsm_top uut (.clk(clk), .rst_n(rst_n), .x_in(x_in), .mop_out(mop_out));

    always #2.5 clk = ~clk;

    // Reference transition table written as direct behaviour.
    task automatic model(input int s, input logic [2:0] x, output int n, output logic [5:0] w);
        case (s)
            0: if (x[0]) begin n = 1; w = W0; end else begin n = 2; w = W1; end
            1: if (x[1]) begin n = 3; w = W0; end else begin n = 4; w = W1; end
            2: if (x[2]) begin n = 5; w = W2; end else begin n = 2; w = W1; end
            3: if (x[0] && x[1]) begin n = 0; w = W3; end else begin n = 5; w = W2; end
            4: if (x[2]) begin n = 0; w = W3; end else begin n = 1; w = W0; end
            default: if (x[1]) begin n = 0; w = W2; end else begin n = 4; w = W1; end
        endcase
    endtask

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: mop_out=%b expected %b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // One transition; entered and left at rising edge + 0.5 ns.
    task automatic step(input logic [2:0] x, input string tag);
        int n;
        logic [5:0] w;
        x_in = x;
        @(negedge clk); #0.5;
        model(mstate, x, n, w);
        check(tag, mop_out, w);
        last_y = mop_out;
        mstate = n;
        @(posedge clk); #0.5;
        check("R7", mop_out, last_y);
    endtask

    // Reset for a number of cycles while inputs keep changing.
    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            x_in = 3'($urandom_range(0, 7));
            @(negedge clk); #0.5;
            check("R1", mop_out, 6'b000000);
            @(posedge clk); #0.5;
        end
        rst_n = 1'b1;
        mstate = 0;
    endtask

    initial begin
        #500000;
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(posedge clk); #0.5;
        do_reset(3);
        step(3'b000, "R1");                 // first transition from S0

        do_reset(2);
        // R5: every microinstruction word appears
        step(3'b001, "R5"); step(3'b000, "R5"); step(3'b100, "R5");
        step(3'b000, "R5"); step(3'b100, "R5");
        // R4: condition priority, S3 with one of x0/x1 takes the default
        step(3'b010, "R4"); step(3'b001, "R4"); step(3'b010, "R4");
        step(3'b001, "R4"); step(3'b000, "R4"); step(3'b000, "R4");
        step(3'b010, "R4"); step(3'b111, "R4"); step(3'b101, "R4");
        step(3'b111, "R4");
        // R6: shared microinstruction, distinct targets
        do_reset(2);
        step(3'b001, "R6"); step(3'b010, "R6"); step(3'b110, "R6");
        step(3'b110, "R6"); step(3'b000, "R6"); step(3'b000, "R6");
        step(3'b100, "R6"); step(3'b000, "R6"); step(3'b000, "R6");
        step(3'b010, "R6");

        // R2 R3: random walks with mid-run resets
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 600; i++) begin
                step(3'($urandom_range(0, 7)), "R2 R3");
            end
            do_reset(2);
            step(3'($urandom_range(0, 7)), "R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule